// File: doc/BRIEF.md
# Dilated Self-Routing Circuit Switch

This block is one switching element of a circuit-switched multistage network. Each of its inputs can open a connection by presenting a header. The lowest header bit picks one of two logical directions, down or up. Each direction is served by two physical output ports, so the element has four outputs. The element looks for a free port in the requested direction. When both ports are free, an internal linear feedback shift register makes a pseudo-random choice between them. The header, shifted right by one bit, is forwarded on the chosen port. From then on the path stays locked and carries data until the source closes it.

A request that finds both ports of its direction occupied is not queued. The element returns a one-cycle drop pulse to the source and allocates nothing, so the source is free to retry later. Requests arriving in the same cycle are handled in a fixed input order: the lowest-numbered input chooses first, and the inputs after it choose among the ports it left.

Top module: `dilated_circuit_switch`

## Requirements
- R1: After reset, every output port is free, no input is linked, and the drop, setup and data outputs are all zero.
- R2: Header bit 0 of a request selects the direction. A 0 grants port 0 or 1, and a 1 grants port 2 or 3. The granted port index (bit 1 = direction) appears on `port_o` of that input while it is linked. An idle input shows 0 there.
- R3: A grant raises `setup_o` on the chosen port for exactly the one cycle after the request edge. During that pulse, the port's `hdr_o` field holds the request header shifted right by one, with a zero as its top bit.
- R4: Only a port that was free before the request edge can be granted. An output port never belongs to two inputs, and a linked input owns exactly one port.
- R5: When both ports of the requested direction are free, either one may be chosen. Over a run, both choices occur.
- R6: When neither port of the requested direction is available, the input gets a one-cycle `drop_o` pulse in the cycle after the request. It stays unlinked and no port changes state.
- R7: Simultaneous requests are served in ascending input order. A lower input's grant removes that port from the choices of every higher input in the same cycle.
- R8: While linked, the owned port stays busy, and its `dout_o` field follows the owner's `din_i` combinationally. A port that is not busy outputs zero.
- R9: Asserting `close_i` on a linked input frees its port and clears its link at the next edge. The port can be granted again from the following request on.
- R10: A request from an input that is already linked is ignored. It causes no drop, no setup and no change of port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_IN | Connection request per input, sampled at the edge |
| close_i | input | N_IN | Release of the connection held by the input |
| hdr_i | input | N_IN*HDR_W | Header per input; bit 0 is this stage's routing bit |
| din_i | input | N_IN*DATA_W | Data from each input for its locked path |
| drop_o | output | N_IN | One-cycle blocked indication back to the source |
| link_o | output | N_IN | Input currently owns an output port |
| port_o | output | N_IN*2 | Index of the port owned by each input |
| busy_o | output | 4 | Output port allocated |
| setup_o | output | 4 | One-cycle pulse when a port is newly allocated |
| hdr_o | output | 4*HDR_W | Forwarded header per output port |
| dout_o | output | 4*DATA_W | Data per output port from its owner |

## Verification
The bench builds the element with four inputs, 4-bit headers, 8-bit data and the default 8-bit register for the random choice. With four inputs facing two ports per direction, three or four requests can aim at one direction in the same cycle, which reaches the drop path and the input-order priority. A lone request into an empty direction exercises the random pick. Random traffic then mixes closes with requests from inputs that are already linked. This shows that a port freed by a close is not available in the same cycle but is available in the next.

// File: rtl/dilated_circuit_switch.sv
module dilated_circuit_switch #(
  parameter int N_IN = 4,
  parameter int HDR_W = 4,
  parameter int DATA_W = 8,
  parameter int LFSR_W = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h5A
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_IN-1:0]          req_i,
  input  logic [N_IN-1:0]          close_i,
  input  logic [N_IN*HDR_W-1:0]    hdr_i,
  input  logic [N_IN*DATA_W-1:0]   din_i,
  output logic [N_IN-1:0]          drop_o,
  output logic [N_IN-1:0]          link_o,
  output logic [N_IN*2-1:0]        port_o,
  output logic [3:0]               busy_o,
  output logic [3:0]               setup_o,
  output logic [4*HDR_W-1:0]       hdr_o,
  output logic [4*DATA_W-1:0]      dout_o
);
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1;

  logic [LFSR_W-1:0] lfsr;
  logic [IW-1:0]     own_q [4];
  logic [1:0]        port_q [N_IN];
  logic [HDR_W-1:0]  fwd [N_IN];
  logic [DATA_W-1:0] dat [N_IN];
  logic [1:0]        avail [N_IN];
  logic [1:0]        gport [N_IN];
  logic [IW-1:0]     gsrc [4];
  logic [N_IN-1:0]   grant, drop_n;
  logic [3:0]        taken, rel;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    assign fwd[i] = hdr_i[i*HDR_W +: HDR_W] >> 1;
    assign dat[i] = din_i[i*DATA_W +: DATA_W];
    assign port_o[i*2 +: 2] = port_q[i];
  end

  always_comb begin
    taken = '0;
    grant = '0;
    drop_n = '0;
    for (int o = 0; o < 4; o++) gsrc[o] = '0;
    for (int i = 0; i < N_IN; i++) begin
      logic dir, sel;
      dir = hdr_i[i*HDR_W];
      avail[i] = dir ? ~(busy_o[3:2] | taken[3:2]) : ~(busy_o[1:0] | taken[1:0]);
      sel = (&avail[i]) ? lfsr[i % LFSR_W] : avail[i][1];
      gport[i] = {dir, sel};
      if (req_i[i] && !link_o[i]) begin
        if (|avail[i]) begin
          grant[i] = 1'b1;
          taken[{dir, sel}] = 1'b1;
          gsrc[{dir, sel}] = IW'(i);
        end else begin
          drop_n[i] = 1'b1;
        end
      end
    end
  end

  always_comb
    for (int o = 0; o < 4; o++) begin
      rel[o] = busy_o[o] & close_i[own_q[o]];
      dout_o[o*DATA_W +: DATA_W] = busy_o[o] ? dat[own_q[o]] : '0;
    end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr    <= LFSR_SEED;
      busy_o  <= '0;
      setup_o <= '0;
      hdr_o   <= '0;
      drop_o  <= '0;
      link_o  <= '0;
      for (int o = 0; o < 4; o++) own_q[o] <= '0;
      for (int i = 0; i < N_IN; i++) port_q[i] <= '0;
    end else begin
      lfsr    <= (lfsr >> 1) ^ (lfsr[0] ? LFSR_TAPS : '0);
      busy_o  <= (busy_o & ~rel) | taken;
      setup_o <= taken;
      drop_o  <= drop_n;
      for (int o = 0; o < 4; o++)
        if (taken[o]) begin
          own_q[o] <= gsrc[o];
          hdr_o[o*HDR_W +: HDR_W] <= fwd[gsrc[o]];
        end
      for (int i = 0; i < N_IN; i++)
        if (grant[i]) begin
          link_o[i] <= 1'b1;
          port_q[i] <= gport[i];
        end else if (link_o[i] && close_i[i]) begin
          link_o[i] <= 1'b0;
          port_q[i] <= '0;
        end
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_chk_in
    logic [3:0] mine;
    always_comb
      for (int o = 0; o < 4; o++) mine[o] = busy_o[o] && (own_q[o] == IW'(i));

    a_r4_one_port_per_input: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mine) == int'(link_o[i]));
    a_r2_dir_follows_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_o[i]) |-> port_o[i*2+1] == $past(hdr_i[i*HDR_W]));
    a_r6_drop_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      drop_o[i] |-> ($past(hdr_i[i*HDR_W]) ? &$past(busy_o[3:2] | taken[3:2])
                                           : &$past(busy_o[1:0] | taken[1:0])));
    a_r9_close_frees: assert property (@(posedge clk) disable iff (!rst_n)
      link_o[i] && close_i[i] |=> !link_o[i]);
    a_r10_linked_holds: assert property (@(posedge clk) disable iff (!rst_n)
      link_o[i] && !close_i[i] |=> link_o[i] && $stable(port_o[i*2 +: 2]) && !drop_o[i]);
  end

  for (genvar o = 0; o < 4; o++) begin : g_chk_out
    a_r3_setup_on_free: assert property (@(posedge clk) disable iff (!rst_n)
      setup_o[o] |-> busy_o[o] && !$past(busy_o[o]));
    a_r3_setup_single: assert property (@(posedge clk) disable iff (!rst_n)
      setup_o[o] |=> !setup_o[o]);
  end
endmodule

// File: tb/dilated_circuit_switch_tb.sv
module dilated_circuit_switch_tb;
  localparam int N = 4, HW = 4, DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req_i = '0, close_i = '0;
  logic [N*HW-1:0] hdr_i = '0;
  logic [N*DW-1:0] din_i = '0;
  logic [N-1:0] drop_o, link_o;
  logic [N*2-1:0] port_o;
  logic [3:0] busy_o, setup_o;
  logic [4*HW-1:0] hdr_o;
  logic [4*DW-1:0] dout_o;

  int total = 0, bad = 0;
  int mbusy[4], mown[4], mlink[N], mport[N];
  int pick_lo = 0, pick_hi = 0;

  always #2.5 clk = ~clk;

  dilated_circuit_switch #(.N_IN(N), .HDR_W(HW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .close_i(close_i), .hdr_i(hdr_i),
    .din_i(din_i), .drop_o(drop_o), .link_o(link_o), .port_o(port_o),
    .busy_o(busy_o), .setup_o(setup_o), .hdr_o(hdr_o), .dout_o(dout_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic check_data();
    for (int o = 0; o < 4; o++) begin
      int e;
      e = mbusy[o] ? int'(din_i[mown[o]*DW +: DW]) : 0;
      chk(int'(dout_o[o*DW +: DW]) == e, "R8 dout", int'(dout_o[o*DW +: DW]), e);
    end
  endtask

  task automatic step(input logic [N-1:0] rq, input logic [N-1:0] cl, input logic [N*HW-1:0] hd);
    logic [3:0] taken;
    logic [N-1:0] edrop;
    int eb;
    req_i = rq; close_i = cl; hdr_i = hd;
    din_i = {$urandom, $urandom};
    #1 check_data();
    @(posedge clk); @(negedge clk);
    taken = '0; edrop = '0;
    for (int i = 0; i < N; i++) begin
      if (rq[i] && mlink[i] == 0) begin
        int dir, p;
        logic [1:0] fr;
        dir = int'(hd[i*HW]);
        for (int k = 0; k < 2; k++) fr[k] = (mbusy[dir*2+k] == 0) && !taken[dir*2+k];
        if (fr == 2'b00) edrop[i] = 1'b1;
        else begin
          p = int'(port_o[i*2 +: 2]);
          chk(link_o[i] == 1'b1, "R4 grant links", int'(link_o[i]), 1);
          chk(p/2 == dir, "R2 direction", p/2, dir);
          chk(fr[p%2] == 1'b1, "R4 free port only", p, dir*2);
          chk(int'(hdr_o[p*HW +: HW]) == int'(hd[i*HW +: HW] >> 1), "R3 forwarded header",
              int'(hdr_o[p*HW +: HW]), int'(hd[i*HW +: HW] >> 1));
          if (fr == 2'b11) begin
            if (p%2 == 0) pick_lo++; else pick_hi++;
          end
          taken[p] = 1'b1;
          mown[p] = i; mlink[i] = 2; mport[i] = p;
        end
      end
    end
    chk(drop_o == edrop, "R6 drop", int'(drop_o), int'(edrop));
    chk(setup_o == taken, "R3 setup", int'(setup_o), int'(taken));
    for (int i = 0; i < N; i++)
      if (cl[i] && mlink[i] == 1) begin
        mbusy[mport[i]] = 0; mlink[i] = 0; mport[i] = 0;
      end
    for (int o = 0; o < 4; o++) if (taken[o]) mbusy[o] = 1;
    for (int i = 0; i < N; i++) if (mlink[i] == 2) mlink[i] = 1;
    eb = 0;
    for (int o = 0; o < 4; o++) eb |= mbusy[o] << o;
    chk(int'(busy_o) == eb, "R9 busy map", int'(busy_o), eb);
    for (int i = 0; i < N; i++) begin
      chk(int'(link_o[i]) == mlink[i], "R10 link", int'(link_o[i]), mlink[i]);
      chk(int'(port_o[i*2 +: 2]) == mport[i], "R10 port", int'(port_o[i*2 +: 2]), mport[i]);
    end
    req_i = '0; close_i = '0;
  endtask

  initial begin
    #1000000;
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int o = 0; o < 4; o++) begin mbusy[o] = 0; mown[o] = 0; end
    for (int i = 0; i < N; i++) begin mlink[i] = 0; mport[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(busy_o == 4'h0 && link_o == '0, "R1 reset state", int'(busy_o), 0);
    chk(drop_o == '0 && setup_o == '0 && dout_o == '0, "R1 reset outputs", int'(setup_o), 0);
    @(negedge clk);
    step(4'b0001, 4'b0000, 16'h000A);   // R2 down, R3 header 1010 -> 0101
    step(4'b0010, 4'b0000, 16'h00E0);   // R4 input 1 takes the other down port
    step(4'b0100, 4'b0000, 16'h0400);   // R6 down full -> drop
    step(4'b0001, 4'b0000, 16'h0001);   // R10 linked input ignored
    step(4'b0000, 4'b0001, 16'h0000);   // R9 close input 0
    step(4'b0100, 4'b0000, 16'h0600);   // R9 freed port reusable
    step(4'b0000, 4'b1111, 16'h0000);
    step(4'b1111, 4'b0000, 16'h3535);   // R7 all up: 0,1 win, 2,3 drop
    step(4'b0000, 4'b0011, 16'h0000);
    for (int n = 0; n < 40; n++) begin  // R5 lone request into empty direction
      step(4'b0001, 4'b0000, 16'(n & 1));
      step(4'b0000, 4'b0001, 16'h0000);
    end
    for (int n = 0; n < 800; n++)
      step(4'($urandom), 4'($urandom) & 4'($urandom), 16'($urandom));
    chk(pick_lo > 0 && pick_hi > 0, "R5 both choices seen", pick_lo, pick_hi);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule